// File: doc/BRIEF.md
# Line-Crossing Store Splitter

This block sits between a store pipeline and a data memory port. It takes one store request (address, byte count, data word, flags and a prefetch hint) and checks whether the written bytes run past the end of a cache line. A store that stays inside one line becomes a single memory write. A store that runs past the line end becomes two writes, sent strictly one after the other. Each write carries its own address, byte count, byte-lane data and byte enables, so that no write ever touches two lines.

While the store is in progress the requester sees a stall and cannot hand over a new store. Each memory write finishes when its acknowledgement pulse arrives. For a prefetch-hinted store, each write finishes as soon as memory accepts it. When every part has finished, the block raises one completion pulse. That pulse reports the original start address and the full byte count, as if the store had been a single access.

Top module: `store_split_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid`, `stall` and `done` are 0.
- R2: `req_size` selects the byte count: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. The byte count of each write appears on `mem_size` as a plain number from 1 to 8.
- R3: The block computes the boundary as (address + byte count - 1), rounded down to a multiple of LINE_BYTES. The store is split only when this boundary is strictly above the start address. Otherwise exactly one write is issued, at the original address, with the full byte count.
- R4: The first write of a split store goes to the original address. Its byte count is boundary minus address, and it carries the lowest bytes of the store data.
- R5: The second write of a split store goes to the boundary address. Its byte count is (address + full count) minus boundary. Its data starts at the store data byte whose index equals the first write's byte count. It is presented only after the first write has finished.
- R6: Every write of a store carries the store's flags unchanged on `mem_flags`.
- R7: Lane placement uses a window of 2*DATA_W/8 byte lanes that starts at the address rounded down to DATA_W/8 bytes. Byte j of a write sits on lane (address mod DATA_W/8) + j, in bits [8*lane+7:8*lane] of `mem_data`, and `mem_be` is 1 exactly on the lanes written. All other data lanes are 0.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, the write's address, size, data, enables and flags stay unchanged on the next cycle.
- R9: From the cycle after a store is accepted until its completion, `stall` is 1 and `req_ready` is 0. A new store is accepted only while idle.
- R10: `done` is a one-cycle pulse. It is raised only after every write of the store has finished, which is two writes for a split store. While it is raised, `done_addr` shows the original address and `done_size` shows the full byte count.
- R11: For a store with `req_prefetch` set, each write finishes on the cycle memory accepts it (`mem_valid` and `mem_ready` both 1), without waiting for `mem_ack`. For other stores, a write finishes only on a `mem_ack` pulse that arrives after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Block idle, request is taken on this cycle |
| req_addr | input | ADDR_W | Store start byte address |
| req_size | input | 2 | Size code (1, 2, 4 or 8 bytes) |
| req_data | input | DATA_W | Store data, byte 0 in the low bits |
| req_flags | input | FLAG_W | Request flags copied to each write |
| req_prefetch | input | 1 | Parts finish on acceptance, no ack needed |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write start address |
| mem_size | output | SIZE_W | Write byte count |
| mem_data | output | 2*DATA_W | Lane-placed write data |
| mem_be | output | 2*DATA_W/8 | Byte-lane enables |
| mem_flags | output | FLAG_W | Flags of the store |
| mem_ack | input | 1 | One-cycle write-finished pulse |
| stall | output | 1 | Requester must hold |
| done | output | 1 | Whole-store completion pulse |
| done_addr | output | ADDR_W | Original store address |
| done_size | output | SIZE_W | Original store byte count |

## Verification
Some properties are checked on every cycle:
- each presented write stays inside one line;
- its enable count matches its byte count;
- a write that is waiting for `mem_ready` holds still;
- `stall` and `req_ready` never agree;
- `done` is a single-cycle pulse that never coincides with a pending write.

The split arithmetic itself can only be shown by the bench's scenarios. This covers the boundary position, the part sizes, the data offset of the second part, the flag copy, the two-step ordering, prefetch completion without an ack, and the address and size reported at completion. The bench sends stores that end exactly at a line end, that cross it by one byte, and random stores placed near line ends.

// File: rtl/store_split_pkg.sv
package store_split_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE1 = 3'd1,
        ST_WAIT1  = 3'd2,
        ST_ISSUE2 = 3'd3,
        ST_WAIT2  = 3'd4
    } split_state_e;

    // size code to byte count: 0->1, 1->2, 2->4, 3->8
    function automatic int unsigned size_code_bytes(input logic [1:0] code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/split_calc.sv
module split_calc #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 4,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_code,
    output logic [SIZE_W-1:0] total,
    output logic [ADDR_W-1:0] boundary,
    output logic              crosses,
    output logic [SIZE_W-1:0] size_first,
    output logic [SIZE_W-1:0] size_second
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] last_byte;
    logic [ADDR_W-1:0] end_excl;

    always_comb begin
        total       = SIZE_W'(store_split_pkg::size_code_bytes(size_code));
        end_excl    = addr + ADDR_W'(total);
        last_byte   = end_excl - ADDR_W'(1);
        boundary    = last_byte & ~LINE_MASK;
        crosses     = boundary > addr;
        size_first  = crosses ? SIZE_W'(boundary - addr) : total;
        size_second = crosses ? SIZE_W'(end_excl - boundary) : '0;
    end
endmodule

// File: rtl/lane_place.sv
module lane_place #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4
) (
    input  logic [$clog2(DATA_W/8)-1:0] lane,
    input  logic [SIZE_W-1:0]           size,
    input  logic [SIZE_W-1:0]           offset,
    input  logic [DATA_W-1:0]           data,
    output logic [2*DATA_W/8-1:0]       be,
    output logic [2*DATA_W-1:0]         wdata
);
    localparam int WIN_BYTES = 2 * DATA_W / 8;
    localparam int CW        = SIZE_W + 2;

    logic [DATA_W-1:0]   shifted;
    logic [2*DATA_W-1:0] placed;
    logic [CW-1:0]       lo;
    logic [CW-1:0]       hi;

    always_comb begin
        shifted = data >> {offset, 3'b000};
        placed  = {{DATA_W{1'b0}}, shifted} << {lane, 3'b000};
        lo      = CW'(lane);
        hi      = lo + CW'(size);
    end

    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_lane
        always_comb begin
            be[i]            = (CW'(i) >= lo) && (CW'(i) < hi);
            wdata[8*i +: 8]  = be[i] ? placed[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/store_split_unit.sv
module store_split_unit #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int FLAG_W     = 4,
    parameter int LINE_BYTES = 64,
    parameter int SIZE_W     = $clog2(DATA_W/8) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [DATA_W-1:0]       req_data,
    input  logic [FLAG_W-1:0]       req_flags,
    input  logic                    req_prefetch,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [SIZE_W-1:0]       mem_size,
    output logic [2*DATA_W-1:0]     mem_data,
    output logic [2*DATA_W/8-1:0]   mem_be,
    output logic [FLAG_W-1:0]       mem_flags,
    input  logic                    mem_ack,
    output logic                    stall,
    output logic                    done,
    output logic [ADDR_W-1:0]       done_addr,
    output logic [SIZE_W-1:0]       done_size
);
    import store_split_pkg::*;

    localparam int LANE_W = $clog2(DATA_W/8);

    typedef struct packed {
        split_state_e       st;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  bound;
        logic [SIZE_W-1:0]  total;
        logic [SIZE_W-1:0]  size1;
        logic [SIZE_W-1:0]  size2;
        logic [DATA_W-1:0]  data;
        logic [FLAG_W-1:0]  flags;
        logic               pf;
        logic               split;
        logic [1:0]         cnt;
        logic               done;
    } ctx_t;

    ctx_t s_d, s_q;

    logic [SIZE_W-1:0] c_total, c_size1, c_size2;
    logic [ADDR_W-1:0] c_bound;
    logic              c_cross;

    split_calc #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)
    ) u_calc (
        .addr(req_addr), .size_code(req_size), .total(c_total),
        .boundary(c_bound), .crosses(c_cross),
        .size_first(c_size1), .size_second(c_size2)
    );

    logic              second_q;
    logic [SIZE_W-1:0] part_off;

    always_comb begin
        second_q  = (s_q.st == ST_ISSUE2);
        mem_valid = (s_q.st == ST_ISSUE1) || second_q;
        mem_addr  = second_q ? s_q.bound : s_q.addr;
        mem_size  = second_q ? s_q.size2 : s_q.size1;
        part_off  = second_q ? s_q.size1 : '0;
        mem_flags = s_q.flags;
        req_ready = (s_q.st == ST_IDLE);
        stall     = (s_q.st != ST_IDLE);
        done      = s_q.done;
        done_addr = s_q.addr;
        done_size = s_q.total;
    end

    lane_place #(
        .DATA_W(DATA_W), .SIZE_W(SIZE_W)
    ) u_lane (
        .lane(mem_addr[LANE_W-1:0]), .size(mem_size), .offset(part_off),
        .data(s_q.data), .be(mem_be), .wdata(mem_data)
    );

    logic [1:0] cnt_inc;
    logic [1:0] need;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        cnt_inc  = s_q.cnt + 2'd1;
        need     = s_q.split ? 2'd2 : 2'd1;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_ISSUE1;
                    s_d.addr  = req_addr;
                    s_d.bound = c_bound;
                    s_d.total = c_total;
                    s_d.size1 = c_size1;
                    s_d.size2 = c_size2;
                    s_d.data  = req_data;
                    s_d.flags = req_flags;
                    s_d.pf    = req_prefetch;
                    s_d.split = c_cross;
                    s_d.cnt   = 2'd0;
                end
            end
            ST_ISSUE1, ST_WAIT1: begin
                if ((s_q.st == ST_ISSUE1 && mem_ready && s_q.pf) ||
                    (s_q.st == ST_WAIT1 && mem_ack)) begin
                    s_d.cnt = cnt_inc;
                    if (s_q.split) begin
                        s_d.st = ST_ISSUE2;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = (cnt_inc == need);
                    end
                end else if (s_q.st == ST_ISSUE1 && mem_ready) begin
                    s_d.st = ST_WAIT1;
                end
            end
            ST_ISSUE2, ST_WAIT2: begin
                if ((s_q.st == ST_ISSUE2 && mem_ready && s_q.pf) ||
                    (s_q.st == ST_WAIT2 && mem_ack)) begin
                    s_d.cnt  = cnt_inc;
                    s_d.st   = ST_IDLE;
                    s_d.done = (cnt_inc == need);
                end else if (s_q.st == ST_ISSUE2 && mem_ready) begin
                    s_d.st = ST_WAIT2;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/store_split_chk.sv
module store_split_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int FLAG_W     = 4,
    parameter int LINE_BYTES = 64,
    parameter int SIZE_W     = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_ready,
    input logic                  mem_valid,
    input logic                  mem_ready,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [SIZE_W-1:0]     mem_size,
    input logic [2*DATA_W-1:0]   mem_data,
    input logic [2*DATA_W/8-1:0] mem_be,
    input logic [FLAG_W-1:0]     mem_flags,
    input logic                  stall,
    input logic                  done
);
    logic [ADDR_W:0] end_in_line;
    always_comb
        end_in_line = {1'b0, mem_addr & ADDR_W'(LINE_BYTES - 1)} + (ADDR_W+1)'(mem_size);

    // R3 R4 R5: every write stays inside one line
    assert_part_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> end_in_line <= (ADDR_W+1)'(LINE_BYTES));

    // R7: enabled lane count equals byte count
    assert_be_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> $countones(mem_be) == int'(mem_size));

    // R8: pending write holds still
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_size)
                                       && $stable(mem_data) && $stable(mem_be) && $stable(mem_flags)));

    // R9: stall and ready are exclusive
    assert_stall_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall != req_ready);

    // R10: single-cycle completion, no write pending at completion
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_valid && req_ready));
endmodule

bind store_split_unit store_split_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W),
    .LINE_BYTES(LINE_BYTES), .SIZE_W(SIZE_W)
) u_chk (.*);

// File: tb/store_split_unit_tb.sv
module store_split_unit_tb;
    localparam int ADDR_W = 32, DATA_W = 64, FLAG_W = 4, LINE = 64, SIZE_W = 4;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic req_valid = 0, req_ready, req_prefetch = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [FLAG_W-1:0] req_flags = '0;
    logic mem_valid, mem_ready = 0, mem_ack = 0, stall, done;
    logic [ADDR_W-1:0] mem_addr, done_addr;
    logic [SIZE_W-1:0] mem_size, done_size;
    logic [2*DATA_W-1:0] mem_data;
    logic [2*DATA_W/8-1:0] mem_be;
    logic [FLAG_W-1:0] mem_flags;

    int checks = 0, failures = 0;
    bit finished = 0;

    store_split_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W),
                       .LINE_BYTES(LINE), .SIZE_W(SIZE_W)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected part layout from R3/R4/R5
    task automatic exp_part(input logic [31:0] a, input int tot, input int idx,
                            output logic [31:0] pa, output int sz, output int off,
                            output int nparts);
        logic [31:0] b;
        b = ((a + tot - 1) / LINE) * LINE;
        nparts = (b > a) ? 2 : 1;
        if (idx == 0) begin
            pa = a; sz = (nparts == 2) ? int'(b - a) : tot; off = 0;
        end else begin
            pa = b; sz = int'(a + tot - b); off = int'(b - a);
        end
    endtask

    function automatic logic [127:0] exp_data(input logic [63:0] d, input int off,
                                              input int sz, input int lane);
        logic [127:0] w;
        w = {64'b0, d >> (8*off)};
        w = w & ((128'(1) << (8*sz)) - 128'(1));
        return w << (8*lane);
    endfunction

    function automatic logic [15:0] exp_be(input int sz, input int lane);
        return 16'(((32'(1) << sz) - 1) << lane);
    endfunction

    task automatic run_store(input logic [31:0] a, input logic [1:0] code,
                             input logic [63:0] d, input logic [3:0] fl, input bit pf,
                             input int rdly, input int adly);
        int tot, np, sz, off;
        logic [31:0] pa;
        tot = 1 << code;
        req_addr = a; req_size = code; req_data = d; req_flags = fl;
        req_prefetch = pf; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(stall && !req_ready, "R9 stall after accept", {stall, req_ready}, 2'b10);
        exp_part(a, tot, 0, pa, sz, off, np);
        for (int p = 0; p < np; p++) begin
            exp_part(a, tot, p, pa, sz, off, np);
            chk(mem_valid, "R5 part presented", mem_valid, 1);
            chk(mem_addr == pa, p == 0 ? "R4 part addr" : "R5 part addr", mem_addr, pa);
            chk(int'(mem_size) == sz, np == 1 ? "R2 R3 size" : "R4 R5 size", mem_size, sz);
            chk(mem_data == exp_data(d, off, sz, int'(pa % 8)), "R7 data lanes", mem_data,
                exp_data(d, off, sz, int'(pa % 8)));
            chk(mem_be == exp_be(sz, int'(pa % 8)), "R7 byte enables", mem_be,
                exp_be(sz, int'(pa % 8)));
            chk(mem_flags == fl, "R6 flags", mem_flags, fl);
            for (int k = 0; k < rdly; k++) begin
                @(negedge clk);
                chk(mem_valid && mem_addr == pa, "R8 held", mem_addr, pa);
            end
            mem_ready = 1;
            @(negedge clk);
            mem_ready = 0;
            if (!pf) begin
                chk(!mem_valid && !done, "R11 wait for ack", {mem_valid, done}, 0);
                for (int k = 0; k < adly; k++) @(negedge clk);
                mem_ack = 1;
                @(negedge clk);
                mem_ack = 0;
            end
            if (p == 0 && np == 2)
                chk(!done, "R10 no done after first part", done, 0);
        end
        chk(done, pf ? "R11 prefetch done" : "R10 done", done, 1);
        chk(done_addr == a && int'(done_size) == tot, "R10 done addr/size",
            {done_addr, done_size}, {a, 4'(tot)});
        chk(req_ready && !stall, "R9 ready at end", {req_ready, stall}, 2'b10);
        @(negedge clk);
        chk(!done, "R10 done pulse", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240531));
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_valid && !stall && !done, "R1 reset",
            {req_ready, mem_valid, stall, done}, 4'b1000);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !mem_valid && !stall && !done, "R1 after reset",
            {req_ready, mem_valid, stall, done}, 4'b1000);
        // directed corners
        run_store(32'h0000_0000, 2'd3, 64'h8877665544332211, 4'h1, 0, 0, 0);
        run_store(32'h0000_0038, 2'd3, 64'h0102030405060708, 4'h2, 0, 1, 2);  // ends at line end
        run_store(32'h0000_003F, 2'd1, 64'h000000000000BEEF, 4'h3, 0, 0, 0);  // 1 + 1
        run_store(32'h0000_107C, 2'd3, 64'hDEADBEEFCAFEF00D, 4'h5, 0, 2, 1);  // 4 + 4
        run_store(32'h0000_2039, 2'd3, 64'hA1B2C3D4E5F60718, 4'h6, 0, 0, 3);  // 7 + 1
        run_store(32'h0000_007E, 2'd2, 64'h0000000012345678, 4'h9, 1, 1, 0);  // prefetch split
        run_store(32'h0000_0003, 2'd3, 64'hFEDCBA9876543210, 4'hA, 1, 0, 0);  // prefetch single
        run_store(32'h0000_0013, 2'd0, 64'h00000000000000AB, 4'hF, 0, 0, 0);
        // random near line ends
        for (int n = 0; n < 80; n++) begin
            logic [31:0] a;
            a = ($urandom % 256) * LINE + (LINE - 1 - ($urandom % 10));
            if ($urandom % 4 == 0) a = $urandom % 4096;
            run_store(a, 2'($urandom % 4), {$urandom, $urandom}, 4'($urandom),
                      ($urandom % 5) == 0, $urandom % 3, $urandom % 3);
        end
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule